// File: doc/BRIEF.md
# Four-Level Page Table Walker

The walker turns a 64-bit virtual address into a 40-bit physical address. It does this by reading four levels of translation tables from a memory port whose words are 64 bits wide. A request carries the virtual address and three access-type flags: write, user mode and instruction fetch. The walker first checks that the address is canonical. It then reads one table entry per level, starting from the table whose frame number sits on the root input. After the last level it returns either the physical address or a fault code together with the level at which the walk stopped.

The memory port allows one read in flight. The walker raises a one-cycle read strobe with an 8-byte-aligned address. The memory later answers with a one-cycle completion strobe that carries the entry. The response port uses a valid/ready handshake. A new request is taken only after the previous response has been handed over.

Top module: `pgwalk_top`

## Requirements
- R1: An address whose bits 63:48 do not all equal bit 47 is answered with fault code 1 (non-canonical) at level 4, and no memory read is issued for it.
- R2: The walk reads level 4 first and level 1 last. At level L the index is the 9-bit field at bits 12+9(L-1) upward (level 4 uses bits 47:39, level 1 uses bits 20:12). The read address is the current table frame times 4096 plus the index times 8. The level-4 frame comes from `root_frame`.
- R3: Each later table frame is taken from entry bits 39:12. A walk without a fault returns fault code 0 at level 1, with physical address = {leaf entry bits 39:12, virtual bits 11:0}.
- R4: An entry with bit 0 (present) clear ends the walk with fault code 2 at the current level, even when its reserved bits are nonzero. Every fault response carries physical address 0.
- R5: A present entry with any of bits 51:40 set ends the walk with fault code 3 at the current level.
- R6: A write request faults with code 4 (protection) at level 1 unless bit 1 is set in the entries of all four levels.
- R7: A user-mode request faults with code 4 at level 1 unless bit 2 is set in the entries of all four levels.
- R8: An instruction fetch faults with code 4 at level 1 when `nx_enable` is 1 and any of the four entries has bit 63 set. When `nx_enable` is 0, bit 63 has no effect on the result. Bit 63 never affects reads or writes.
- R9: Only one request is handled at a time. `req_ready` stays low from acceptance until the response handshake completes. A response held by `rsp_ready` low keeps its values unchanged. At most one memory read is in flight.
- R10: After reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| nx_enable | input | 1 | Lets entry bit 63 forbid fetches |
| root_frame | input | 28 | Frame number of the level-4 table |
| mem_rd_req | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 40 | Byte address of the entry to read |
| mem_rd_done | input | 1 | One-cycle read completion strobe |
| mem_rd_data | input | 64 | Entry returned with the completion strobe |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 40 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 reserved, 4 protection |
| rsp_level | output | 3 | Level (1 to 4) at which the walk ended |

## Verification
A wrong level counter or index selection shows up at once on `mem_rd_addr`. It then spreads to a wrong leaf frame in `rsp_paddr`, or to a not-present fault at the wrong level, within the same walk. A permission accumulator that is not reset between requests does not show up on the request that corrupts it. It appears only on the next request that depends on that permission, so the tests place permissive walks directly after restrictive ones. A broken canonical check is visible one cycle after acceptance as a fault with no preceding read strobe. Handshake errors appear as a second acceptance while a response is still pending, or as response fields that change during a stall.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int unsigned PGW_VA_W   = 64;
  localparam int unsigned PGW_ENT_W  = 64;
  localparam int unsigned PGW_PA_W   = 40;
  localparam int unsigned PGW_IDX_W  = 9;
  localparam int unsigned PGW_OFF_W  = 12;
  localparam int unsigned PGW_LEVELS = 4;
  localparam int unsigned PGW_RSV_HI = 51;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_NONCANON    = 3'd1,
    FLT_NOT_PRESENT = 3'd2,
    FLT_RESERVED    = 3'd3,
    FLT_PROTECT     = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walk_st_e;

  typedef struct packed {
    logic present;
    logic rsv_bad;
    logic wr;
    logic usr;
    logic xd;
  } ent_flags_t;

endpackage

// File: rtl/pgwalk_canon.sv
module pgwalk_canon #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned IMPL_W = 48
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            canon
);
  // Sign-extension group: the implemented top bit and everything above it.
  localparam int unsigned EXT_LO = IMPL_W - 1;

  logic [VA_W-1:EXT_LO] ext_bits;

  always_comb begin
    ext_bits = vaddr[VA_W-1:EXT_LO];
    canon    = (&ext_bits) | ~(|ext_bits);
  end
endmodule

// File: rtl/pgwalk_idx_sel.sv
module pgwalk_idx_sel #(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned LEVELS = 4
) (
  input  logic [OFF_W+LEVELS*IDX_W-1:0] va_impl,
  input  logic [2:0]                    level,
  output logic [IDX_W-1:0]              idx
);
  logic [IDX_W-1:0] fld [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = va_impl[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == 3'(i + 1)) idx = fld[i];
    end
  end
endmodule

// File: rtl/pgwalk_entry_dec.sv
module pgwalk_entry_dec
  import pgwalk_pkg::*;
#(
  parameter int unsigned ENT_W  = 64,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned RSV_HI = 51
) (
  input  logic [ENT_W-1:0]      entry,
  input  logic                  nx_en,
  output ent_flags_t            flags,
  output logic [PA_W-OFF_W-1:0] frame
);
  logic unused_bits;

  always_comb begin
    flags.present = entry[0];
    flags.wr      = entry[1];
    flags.usr     = entry[2];
    flags.rsv_bad = |entry[RSV_HI:PA_W];
    flags.xd      = entry[ENT_W-1] & nx_en;
    frame         = entry[PA_W-1:OFF_W];
  end

  assign unused_bits = ^{entry[ENT_W-2:RSV_HI+1], entry[OFF_W-1:3]};
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned VA_W   = PGW_VA_W,
  parameter int unsigned ENT_W  = PGW_ENT_W,
  parameter int unsigned PA_W   = PGW_PA_W,
  parameter int unsigned IDX_W  = PGW_IDX_W,
  parameter int unsigned OFF_W  = PGW_OFF_W,
  parameter int unsigned LEVELS = PGW_LEVELS,
  parameter int unsigned RSV_HI = PGW_RSV_HI
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  input  logic                  req_user,
  input  logic                  req_fetch,
  input  logic                  nx_enable,
  input  logic [PA_W-OFF_W-1:0] root_frame,
  output logic                  mem_rd_req,
  output logic [PA_W-1:0]       mem_rd_addr,
  input  logic                  mem_rd_done,
  input  logic [ENT_W-1:0]      mem_rd_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [2:0]            rsp_fault,
  output logic [2:0]            rsp_level
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;
  localparam int unsigned VA_IMPL = OFF_W + LEVELS * IDX_W;
  localparam int unsigned ENT_SH  = $clog2(ENT_W / 8);

  walk_st_e            st_q, st_d;
  logic [VA_IMPL-1:0]  va_q, va_d;
  logic                wr_q, wr_d, us_q, us_d, fe_q, fe_d;
  logic [2:0]          lvl_q, lvl_d;
  logic [FRAME_W-1:0]  frame_q, frame_d;
  logic                acc_w_q, acc_w_d, acc_u_q, acc_u_d, acc_x_q, acc_x_d;
  fault_e              fault_q, fault_d;
  logic [PA_W-1:0]     paddr_q, paddr_d;

  logic                canon_req;
  logic [IDX_W-1:0]    cur_idx;
  ent_flags_t          ent_fl;
  logic [FRAME_W-1:0]  ent_frame;
  logic                w_n, u_n, x_n, deny;

  pgwalk_canon #(.VA_W(VA_W), .IMPL_W(VA_IMPL)) u_canon (
    .vaddr (req_vaddr),
    .canon (canon_req)
  );

  pgwalk_idx_sel #(.IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)) u_idx (
    .va_impl (va_q),
    .level   (lvl_q),
    .idx     (cur_idx)
  );

  pgwalk_entry_dec #(.ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W), .RSV_HI(RSV_HI)) u_dec (
    .entry (mem_rd_data),
    .nx_en (nx_enable),
    .flags (ent_fl),
    .frame (ent_frame)
  );

  // Port-side decode of the state register.
  always_comb begin
    req_ready   = (st_q == ST_IDLE);
    mem_rd_req  = (st_q == ST_ISSUE);
    rsp_valid   = (st_q == ST_RESP);
    mem_rd_addr = {frame_q, {OFF_W{1'b0}}} + (PA_W'(cur_idx) << ENT_SH);
    rsp_paddr   = paddr_q;
    rsp_fault   = fault_q;
    rsp_level   = lvl_q;
  end

  // Permissions after folding in the entry now arriving.
  always_comb begin
    w_n  = acc_w_q & ent_fl.wr;
    u_n  = acc_u_q & ent_fl.usr;
    x_n  = acc_x_q | ent_fl.xd;
    deny = (wr_q & ~w_n) | (us_q & ~u_n) | (fe_q & x_n);
  end

  // Next-state logic.
  always_comb begin
    st_d    = st_q;
    va_d    = va_q;
    wr_d    = wr_q;
    us_d    = us_q;
    fe_d    = fe_q;
    lvl_d   = lvl_q;
    frame_d = frame_q;
    acc_w_d = acc_w_q;
    acc_u_d = acc_u_q;
    acc_x_d = acc_x_q;
    fault_d = fault_q;
    paddr_d = paddr_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d    = req_vaddr[VA_IMPL-1:0];
          wr_d    = req_write;
          us_d    = req_user;
          fe_d    = req_fetch;
          lvl_d   = 3'(LEVELS);
          frame_d = root_frame;
          acc_w_d = 1'b1;
          acc_u_d = 1'b1;
          acc_x_d = 1'b0;
          paddr_d = '0;
          if (canon_req) begin
            fault_d = FLT_NONE;
            st_d    = ST_ISSUE;
          end else begin
            fault_d = FLT_NONCANON;
            st_d    = ST_RESP;
          end
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rd_done) begin
          if (!ent_fl.present) begin
            fault_d = FLT_NOT_PRESENT;
            st_d    = ST_RESP;
          end else if (ent_fl.rsv_bad) begin
            fault_d = FLT_RESERVED;
            st_d    = ST_RESP;
          end else begin
            acc_w_d = w_n;
            acc_u_d = u_n;
            acc_x_d = x_n;
            frame_d = ent_frame;
            if (lvl_q == 3'd1) begin
              st_d = ST_RESP;
              if (deny) fault_d = FLT_PROTECT;
              else      paddr_d = {ent_frame, va_q[OFF_W-1:0]};
            end else begin
              lvl_d = lvl_q - 3'd1;
              st_d  = ST_ISSUE;
            end
          end
        end
      end
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      us_q    <= 1'b0;
      fe_q    <= 1'b0;
      lvl_q   <= 3'(LEVELS);
      frame_q <= '0;
      acc_w_q <= 1'b1;
      acc_u_q <= 1'b1;
      acc_x_q <= 1'b0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      st_q    <= st_d;
      va_q    <= va_d;
      wr_q    <= wr_d;
      us_q    <= us_d;
      fe_q    <= fe_d;
      lvl_q   <= lvl_d;
      frame_q <= frame_d;
      acc_w_q <= acc_w_d;
      acc_u_q <= acc_u_d;
      acc_x_q <= acc_x_d;
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  AST_NONCANON_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !canon_req) |=> (rsp_valid && rsp_fault == 3'(FLT_NONCANON) && !mem_rd_req)); // R1
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[ENT_SH-1:0] == '0)); // R2
  AST_OK_AT_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'(FLT_NONE)) |-> (rsp_level == 3'd1)); // R3
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'(FLT_NONE)) |-> (rsp_paddr == '0)); // R4
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_level >= 3'd1 && rsp_level <= 3'(LEVELS))); // R4
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_level))); // R9
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid); // R9
endmodule

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        req_fetch = 1'b0;
  logic        nx_enable = 1'b0;
  logic [27:0] root_frame = 28'h0000100;
  logic        mem_rd_req;
  logic [39:0] mem_rd_addr;
  logic        mem_rd_done = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [39:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic [2:0]  rsp_level;

  always #2 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
    .nx_enable(nx_enable), .root_frame(root_frame),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_done(mem_rd_done), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rd_count = 0;
  int cyc = 0;
  bit finished = 0;

  logic [63:0] mem [logic [39:0]];

  typedef struct {
    logic [39:0] pa;
    logic [2:0]  flt;
    logic [2:0]  lvl;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Memory model: two cycles from read strobe to completion.
  logic [39:0] pend_addr = '0;
  int          pend_cnt = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_ready <= (cyc % 3) != 2;
    mem_rd_done <= 1'b0;
    if (pend_cnt == 1) begin
      mem_rd_done <= 1'b1;
      mem_rd_data <= mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
    end
    if (pend_cnt != 0) pend_cnt <= pend_cnt - 1;
    if (rst_n && mem_rd_req) begin
      pend_addr <= mem_rd_addr;
      pend_cnt  <= 2;
      rd_count  <= rd_count + 1;
    end
  end

  function automatic logic [63:0] ent(input logic [27:0] fr, input logic [11:0] fl);
    return {24'h0, fr, fl};
  endfunction

  function automatic logic [63:0] mkva(input int l4, input int l3, input int l2, input int l1, input int off);
    logic [47:0] lo;
    lo = {9'(l4), 9'(l3), 9'(l2), 9'(l1), 12'(off)};
    return {{16{lo[47]}}, lo};
  endfunction

  function automatic logic [63:0] rd(input logic [39:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // Reference walk written from the requirements.
  task automatic ref_walk(input logic [63:0] va, input bit w, input bit u, input bit f, input bit nx,
                          output logic [39:0] pa, output logic [2:0] flt, output logic [2:0] lvl);
    logic [27:0] fr;
    logic [63:0] e;
    logic [8:0]  ix;
    bit wa, ua, xa;
    pa = '0;
    if (va[63:47] != {17{va[47]}}) begin
      flt = 3'd1; lvl = 3'd4; return;
    end
    fr = root_frame; wa = 1; ua = 1; xa = 0;
    for (int l = 4; l >= 1; l--) begin
      ix = va[12 + 9*(l-1) +: 9];
      e  = rd({fr, 12'h0} + 40'(ix) * 8);
      if (!e[0])        begin flt = 3'd2; lvl = 3'(l); return; end
      if (e[51:40] != 0) begin flt = 3'd3; lvl = 3'(l); return; end
      wa = wa & e[1]; ua = ua & e[2]; xa = xa | (e[63] & nx);
      fr = e[39:12];
    end
    lvl = 3'd1;
    if ((w && !wa) || (u && !ua) || (f && xa)) flt = 3'd4;
    else begin flt = 3'd0; pa = {fr, va[11:0]}; end
  endtask

  // Driver: computes the expected result, queues it, then presents the request.
  task automatic send(input logic [63:0] va, input bit w, input bit u, input bit f, input bit nx, input string tag);
    exp_t x;
    ref_walk(va, w, u, f, nx, x.pa, x.flt, x.lvl);
    x.tag = tag;
    nx_enable = nx;
    exp_q.push_back(x);
    req_vaddr = va; req_write = w; req_user = u; req_fetch = f;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {"R9 busy after accept ", tag}, 64'(req_ready), 64'h0);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each delivered response with the queue head.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", 64'(rsp_fault), 64'h0);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        check({rsp_paddr, rsp_fault, rsp_level} == {x.pa, x.flt, x.lvl}, x.tag,
              64'({rsp_paddr, rsp_fault, rsp_level}), 64'({x.pa, x.flt, x.lvl}));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(cyc), 64'h0);
    finish_run();
  end

  initial begin
    int rc0;
    logic [63:0] t4, t3, t2, t1;
    t4 = 64'h100000; t3 = 64'h101000; t2 = 64'h102000; t1 = 64'h103000;
    mem[40'(t4 + 1*8)]     = ent(28'h101, 12'h007);
    mem[40'(t4 + 9'h100*8)] = ent(28'h101, 12'h007);
    mem[40'(t3 + 2*8)]     = ent(28'h102, 12'h007);
    mem[40'(t3 + 9*8)]     = ent(28'h102, 12'h007) | (64'h1 << 45);
    mem[40'(t2 + 3*8)]     = ent(28'h103, 12'h007);
    mem[40'(t2 + 6*8)]     = ent(28'h103, 12'h005);
    mem[40'(t1 + 4*8)]     = ent(28'h54321, 12'h007);
    mem[40'(t1 + 8*8)]     = ent(28'h54322, 12'h003);
    mem[40'(t1 + 10*8)]    = ent(28'h54323, 12'h007) | 64'h8000_0000_0000_0000;
    mem[40'(t1 + 11*8)]    = 64'h1 << 44;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 req_ready after reset", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0, "R10 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    check(mem_rd_req == 1'b0, "R10 mem_rd_req after reset", 64'(mem_rd_req), 64'h0);

    send(mkva(1, 2, 3, 4, 12'habc), 0, 0, 0, 0, "R2 R3 low-half read");
    send(mkva(9'h100, 2, 3, 4, 12'h123), 1, 1, 0, 0, "R2 R3 high-half user write");

    rc0 = rd_count;
    send(64'h0001_0000_0000_1000, 0, 0, 0, 0, "R1 upper bits set with bit 47 clear");
    check(rd_count == rc0, "R1 no read issued", 64'(rd_count), 64'(rc0));
    send(64'hFFFE_8000_0000_0000, 0, 0, 0, 0, "R1 upper bit cleared with bit 47 set");
    check(rd_count == rc0, "R1 no read issued (2)", 64'(rd_count), 64'(rc0));

    send(mkva(7, 2, 3, 4, 0), 0, 0, 0, 0, "R4 not present at level 4");
    send(mkva(1, 2, 5, 4, 0), 0, 0, 0, 0, "R4 not present at level 2");
    send(mkva(1, 2, 3, 11, 0), 0, 0, 0, 0, "R4 not present wins over reserved");
    send(mkva(1, 9, 3, 4, 0), 0, 0, 0, 0, "R5 reserved at level 3");

    send(mkva(1, 2, 6, 4, 8), 1, 0, 0, 0, "R6 write to read-only");
    send(mkva(1, 2, 6, 4, 8), 0, 0, 0, 0, "R6 read of read-only");
    send(mkva(1, 2, 3, 4, 8), 1, 0, 0, 0, "R6 write permitted after denial");

    send(mkva(1, 2, 3, 8, 16), 0, 1, 0, 0, "R7 user on supervisor page");
    send(mkva(1, 2, 3, 8, 16), 0, 0, 0, 0, "R7 supervisor on supervisor page");

    send(mkva(1, 2, 3, 10, 32), 0, 0, 1, 1, "R8 fetch with no-execute enabled");
    send(mkva(1, 2, 3, 10, 32), 0, 0, 1, 0, "R8 fetch with no-execute disabled");
    send(mkva(1, 2, 3, 10, 32), 0, 0, 0, 1, "R8 read of no-execute page");
    send(mkva(1, 2, 3, 4, 32), 0, 0, 1, 1, "R8 fetch after denial");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all responses delivered", 64'(exp_q.size()), 64'h0);
    finish_run();
  end

endmodule